// File: doc/BRIEF.md
# Multiframe Timing Reference with SYSREF Alignment

This block keeps the local octet, frame and multiframe count for one end of a serial data-converter link. Each clock cycle is one octet time. Octets are grouped into frames of F octets, and frames are grouped into multiframes of K frames. The block marks each frame start and each multiframe start with a strobe. It also reports the index of the current frame within the multiframe.

All devices in the system receive a common SYSREF pulse. The block passes SYSREF through a synchronizer on the device clock and finds its rising edge. After a programmable number of octet times it forces the counters back to the start of a multiframe. Every device therefore lands on the same multiframe phase, or on a phase that differs by a fixed and repeatable amount. Once the block has aligned, a later SYSREF edge that agrees with the running phase leaves the counting untouched. An edge that disagrees realigns the counters and sets a sticky phase-error flag.

F, K and the offset are sampled while reset is held. The link start logic typically waits for the multiframe strobe before it begins its lane alignment sequence.

Top module: `mfclk_align`

## Requirements
- R1: The octet position advances once per clock. `frame_stb` is high exactly when the octet position is 0. The frame length is F = `cfg_f_m1`+1 octets, with F from 1 to 16. `frame_idx` steps by one at each frame start and wraps to 0 after K-1, where K = `cfg_k_m1`+1 and K runs from 1 to 32.
- R2: `mf_stb` is high exactly when `frame_stb` is high and `frame_idx` is 0, so it repeats every F*K cycles.
- R3: While `rst_n` is low, the block holds position 0 (`frame_stb`=1, `mf_stb`=1, `frame_idx`=0) with `sysref_seen`=0 and `phase_err`=0. The configuration inputs are captured at every clock edge during reset.
- R4: Changes to `cfg_f_m1`, `cfg_k_m1` or `cfg_ofs` after reset is released have no effect on the counting.
- R5: A rising edge of `sysref_in` puts the block at position 0 (frame 0, octet 0). This happens at the clock edge that comes SYNC_STAGES+`cfg_ofs` edges after the edge that first samples `sysref_in` high. SYNC_STAGES defaults to 2.
- R6: Only a rising edge of `sysref_in` (high now, low at the previous sample) causes alignment. Holding `sysref_in` high causes no further alignment.
- R7: `sysref_seen` rises at the first alignment and stays high until reset.
- R8: An alignment that falls on the cycle where the counters would wrap to position 0 anyway leaves the counting sequence unchanged and does not set `phase_err`.
- R9: An alignment at any other point still forces position 0. If `sysref_seen` is already set, it also sets `phase_err`, which then stays high until reset. The first alignment never sets `phase_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, one octet time per cycle |
| rst_n | input | 1 | Active-low reset; configuration captured while low |
| cfg_f_m1 | input | 4 | Octets per frame minus one |
| cfg_k_m1 | input | 5 | Frames per multiframe minus one |
| cfg_ofs | input | 9 | Extra octet times from SYSREF edge detection to the forced boundary |
| sysref_in | input | 1 | System reference, asynchronous to nothing but sampled on clk |
| frame_stb | output | 1 | One-cycle pulse at each frame start |
| mf_stb | output | 1 | One-cycle pulse at each multiframe start |
| frame_idx | output | 5 | Current frame index within the multiframe |
| sysref_seen | output | 1 | Sticky: at least one alignment has happened |
| phase_err | output | 1 | Sticky: an alignment disagreed with the running phase |

## Verification
A wrong octet or frame count shows up at the next frame start. In the worst case that is F cycles away, where either the strobe spacing or `frame_idx` goes wrong. A miscounted offset or synchronizer depth moves the forced `mf_stb` by whole cycles, and the cycle-exact comparison against a reference model catches this at the first alignment. A phase comparison with the wrong sense gives itself away at the second SYSREF edge, because `phase_err` rises when the edge agreed or stays low when it did not.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
   localparam int F_MAX_DEF = 16;
   localparam int K_MAX_DEF = 32;
   localparam int OFS_W_DEF = 9;
   localparam int SYNC_DEF  = 2;

   // one alignment request and whether it agrees with the running phase
   typedef struct packed {
      logic fire;
      logic on_wrap;
   } align_evt_t;
endpackage

// File: rtl/mfa_sysref_edge.sv
module mfa_sysref_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sysref_in,
   output logic rise_o
);
   logic last_q;
   logic prev_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) last_q <= 1'b0;
            else        last_q <= sysref_in;
         end
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], sysref_in};
         end
         assign last_q = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= last_q;
   end

   assign rise_o = last_q & ~prev_q;
endmodule

// File: rtl/mfa_align_delay.sv
module mfa_align_delay #(
   parameter int OFS_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OFS_W-1:0] ofs,
   input  logic             rise_i,
   output logic             fire_o
);
   logic             pend_q;
   logic [OFS_W-1:0] dly_q;
   logic             ofs_zero;
   logic             dly_last;

   assign ofs_zero = (ofs == '0);
   assign dly_last = (dly_q == OFS_W'(1));
   assign fire_o   = (rise_i && ofs_zero) || (pend_q && dly_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         dly_q  <= '0;
      end else if (rise_i && !ofs_zero) begin
         pend_q <= 1'b1;
         dly_q  <= ofs;
      end else if (pend_q) begin
         if (dly_last) pend_q <= 1'b0;
         else          dly_q  <= dly_q - OFS_W'(1);
      end
   end
endmodule

// File: rtl/mfa_lmfc_counter.sv
module mfa_lmfc_counter #(
   parameter int FW = 4,
   parameter int KW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] f_m1,
   input  logic [KW-1:0] k_m1,
   input  logic          force_zero,
   output logic [FW-1:0] oct_o,
   output logic [KW-1:0] frm_o,
   output logic          wrap_o
);
   logic oct_end;

   assign oct_end = (oct_o == f_m1);
   assign wrap_o  = oct_end && (frm_o == k_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oct_o <= '0;
         frm_o <= '0;
      end else if (force_zero || wrap_o) begin
         oct_o <= '0;
         frm_o <= '0;
      end else if (oct_end) begin
         oct_o <= '0;
         frm_o <= frm_o + KW'(1);
      end else begin
         oct_o <= oct_o + FW'(1);
      end
   end
endmodule

// File: rtl/mfclk_align.sv
module mfclk_align
   import mfa_pkg::*;
#(
   parameter int F_MAX       = F_MAX_DEF,
   parameter int K_MAX       = K_MAX_DEF,
   parameter int OFS_W       = OFS_W_DEF,
   parameter int SYNC_STAGES = SYNC_DEF,
   localparam int FW = $clog2(F_MAX),
   localparam int KW = $clog2(K_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FW-1:0]    cfg_f_m1,
   input  logic [KW-1:0]    cfg_k_m1,
   input  logic [OFS_W-1:0] cfg_ofs,
   input  logic             sysref_in,
   output logic             frame_stb,
   output logic             mf_stb,
   output logic [KW-1:0]    frame_idx,
   output logic             sysref_seen,
   output logic             phase_err
);
   generate
      if (F_MAX < 2 || F_MAX != (1 << FW)) begin : g_bad_fmax
         $error("F_MAX must be a power of two of at least 2");
      end
      if (K_MAX < 2 || K_MAX != (1 << KW)) begin : g_bad_kmax
         $error("K_MAX must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (OFS_W < 1) begin : g_bad_ofs
         $error("OFS_W must be at least 1");
      end
   endgenerate

   // configuration held from the reset period onward
   logic [FW-1:0]    f_q;
   logic [KW-1:0]    k_q;
   logic [OFS_W-1:0] ofs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_q   <= cfg_f_m1;
         k_q   <= cfg_k_m1;
         ofs_q <= cfg_ofs;
      end
   end

   logic       rise;
   align_evt_t evt;
   logic [FW-1:0] oct;
   logic [KW-1:0] frm;

   mfa_sysref_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sysref_in (sysref_in),
      .rise_o    (rise)
   );

   mfa_align_delay #(.OFS_W(OFS_W)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .ofs    (ofs_q),
      .rise_i (rise),
      .fire_o (evt.fire)
   );

   mfa_lmfc_counter #(.FW(FW), .KW(KW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .f_m1       (f_q),
      .k_m1       (k_q),
      .force_zero (evt.fire),
      .oct_o      (oct),
      .frm_o      (frm),
      .wrap_o     (evt.on_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sysref_seen <= 1'b0;
         phase_err   <= 1'b0;
      end else if (evt.fire) begin
         sysref_seen <= 1'b1;
         if (sysref_seen && !evt.on_wrap) phase_err <= 1'b1;
      end
   end

   assign frame_stb = (oct == '0);
   assign mf_stb    = frame_stb && (frm == '0);
   assign frame_idx = frm;
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
   parameter int KW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_stb,
   input logic          mf_stb,
   input logic [KW-1:0] frame_idx,
   input logic [KW-1:0] k_cfg,
   input logic          sysref_seen,
   input logic          phase_err
);
   AST_MF_WITHIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      mf_stb |-> (frame_stb && frame_idx == '0)); // R2
   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_idx <= k_cfg); // R1
   AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sysref_seen |=> sysref_seen); // R7
   AST_SEEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sysref_seen) |-> mf_stb); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      phase_err |=> phase_err); // R9
   AST_ERR_AFTER_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_err) |-> ($past(sysref_seen) && mf_stb)); // R9
endmodule

bind mfclk_align mfa_checker #(.KW(KW)) u_mfa_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_stb   (frame_stb),
   .mf_stb      (mf_stb),
   .frame_idx   (frame_idx),
   .k_cfg       (k_q),
   .sysref_seen (sysref_seen),
   .phase_err   (phase_err)
);

// File: tb/mfclk_align_tb.sv
module mfclk_align_tb_top;
   localparam int TCK  = 10;
   localparam int SYNC = 2;
   localparam int NV   = 8;
   // f_m1, k_m1, ofs, delta to second edge (0 = none), hold, expected phase_err
   localparam int VEC [NV][6] = '{
      '{ 0,  0,   0,   3,  2, 0},
      '{ 3,  7,   0,  32,  2, 0},
      '{ 3,  7,   3,  33,  2, 1},
      '{15, 31, 100, 512,  2, 0},
      '{ 1,  2,   5,   9,  2, 1},
      '{ 0, 31,   0,   0, 40, 0},
      '{15,  0,   1,  16,  2, 0},
      '{ 2,  4,   2,  20,  2, 1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cfg_f_m1 = '0;
   logic [4:0] cfg_k_m1 = '0;
   logic [8:0] cfg_ofs = '0;
   logic       sysref_in = 1'b0;
   logic       frame_stb, mf_stb, sysref_seen, phase_err;
   logic [4:0] frame_idx;

   int n_run = 0;
   int n_fail = 0;
   bit chk_en = 1'b0;
   string tag = "R1";

   // reference model state
   int cyc = 0;
   int fire_at = -1;
   int m_oct = 0, m_frm = 0, m_f = 0, m_k = 0;
   bit m_seen = 1'b0, m_err = 1'b0;

   always #(TCK/2) clk = ~clk;

   mfclk_align #(.SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_f_m1(cfg_f_m1), .cfg_k_m1(cfg_k_m1),
      .cfg_ofs(cfg_ofs), .sysref_in(sysref_in), .frame_stb(frame_stb),
      .mf_stb(mf_stb), .frame_idx(frame_idx), .sysref_seen(sysref_seen),
      .phase_err(phase_err)
   );

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         m_f = int'(cfg_f_m1); m_k = int'(cfg_k_m1);
         m_oct = 0; m_frm = 0; m_seen = 1'b0; m_err = 1'b0;
      end else if (cyc == fire_at) begin
         if (m_seen && !(m_oct == m_f && m_frm == m_k)) m_err = 1'b1;
         m_seen = 1'b1; m_oct = 0; m_frm = 0;
      end else if (m_oct == m_f) begin
         m_oct = 0;
         m_frm = (m_frm == m_k) ? 0 : m_frm + 1;
      end else begin
         m_oct = m_oct + 1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en) begin
         check({tag, "/R1"}, "frame_stb", int'(frame_stb), int'(m_oct == 0));
         check({tag, "/R2"}, "mf_stb", int'(mf_stb), int'(m_oct == 0 && m_frm == 0));
         check({tag, "/R1"}, "frame_idx", int'(frame_idx), m_frm);
         check({tag, "/R7"}, "sysref_seen", int'(sysref_seen), int'(m_seen));
         check({tag, "/R9"}, "phase_err", int'(phase_err), int'(m_err));
      end
   end

   task automatic raise_sysref(input int ofs);
      sysref_in = 1'b1;
      fire_at = cyc + 1 + SYNC + ofs; // R5 timing
   endtask

   initial begin
      #(TCK*150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      for (int v = 0; v < NV; v++) begin
         int f1, k1, ofs, delta, hold, period;
         f1 = VEC[v][0]; k1 = VEC[v][1]; ofs = VEC[v][2];
         delta = VEC[v][3]; hold = VEC[v][4];
         period = (f1 + 1) * (k1 + 1);
         chk_en = 1'b0;
         sysref_in = 1'b0;
         fire_at = -1;
         rst_n = 1'b0;
         cfg_f_m1 = 4'(f1); cfg_k_m1 = 5'(k1); cfg_ofs = 9'(ofs);
         repeat (3) @(negedge clk);
         // R3: reset state
         check("R3", "frame_stb in reset", int'(frame_stb), 1);
         check("R3", "mf_stb in reset", int'(mf_stb), 1);
         check("R3", "frame_idx in reset", int'(frame_idx), 0);
         check("R3", "sysref_seen in reset", int'(sysref_seen), 0);
         check("R3", "phase_err in reset", int'(phase_err), 0);
         rst_n = 1'b1;
         // R4: configuration moves after reset must not matter
         cfg_f_m1 = ~cfg_f_m1; cfg_k_m1 = ~cfg_k_m1; cfg_ofs = ~cfg_ofs;
         tag = "R4";
         chk_en = 1'b1;
         repeat (5) @(negedge clk);
         tag = "R5";
         raise_sysref(ofs);
         repeat (hold) @(negedge clk);
         sysref_in = 1'b0;
         tag = "R6"; // steady high produced no extra alignment
         if (delta > 0) begin
            repeat (delta - hold) @(negedge clk);
            tag = (VEC[v][5] != 0) ? "R9" : "R8";
            raise_sysref(ofs);
            repeat (2) @(negedge clk);
            sysref_in = 1'b0;
         end
         repeat (2 * period + SYNC + ofs + 8) @(negedge clk);
         if (VEC[v][5] != 0)
            check("R9", "final phase_err", int'(phase_err), 1);
         else
            check("R8", "final phase_err", int'(phase_err), 0);
         check("R7", "final sysref_seen", int'(sysref_seen), 1);
      end
      chk_en = 1'b0;
      // directed: reset clears sticky flags left by the last vector (R3)
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R3", "phase_err cleared", int'(phase_err), 0);
      check("R3", "sysref_seen cleared", int'(sysref_seen), 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule